// File: doc/BRIEF.md
# Trap Entry and Delegation Unit

This block performs the hardware side of taking a trap on a hart that has user, supervisor and machine privilege levels. In the cycle a trap is requested, the caller presents an interrupt/exception flag, a raw cause code, a faulting value, the current PC, the current privilege and the live interrupt-enable bits. The unit chooses which level handles the trap. It then records the entry state in its cause, exception-PC, trap-value and status registers. On the next clock it moves the hart to the handling level and pulses a redirect strobe together with the handler address.

Two delegation masks route the trap. One covers interrupts and one covers exceptions. A trap may go down to supervisor only from supervisor or user level. A single environment-call cause from the decoder becomes a level-specific code. The handler address comes from the trap-vector input of the handling level. Vectored offsets apply to interrupts only.

Top module: `trap_entry_unit`

## Requirements
- R1: The delegation mask consulted is `ideleg_i` when `trap_async_i` is 1 and `edeleg_i` when it is 0.
- R2: A trap is handled in supervisor mode only if the current privilege is user (0) or supervisor (1), the final cause is below XLEN (32), and the mask bit indexed by the final cause is 1. Every other trap, including any trap from machine mode (3), is handled in machine mode.
- R3: The handling level's trap-value register receives `trap_value_i` only for a synchronous trap whose cause is 0, 1, 4, 5, 6, 7, 12, 13 or 15. Every other trap writes zero, and that includes all interrupts.
- R4: A synchronous trap with cause 8 is rewritten before delegation: it stays 8 from user, becomes 9 from supervisor and becomes 11 from machine.
- R5: Supervisor entry sets SPIE to `cur_sie_i`, sets SPP to bit 0 of the current privilege and clears SIE. The machine fields are unchanged.
- R6: Machine entry sets MPIE to `cur_mie_i`, sets MPP to the current privilege and clears MIE. The supervisor fields are unchanged.
- R7: The handling level's cause register is loaded with the final cause, zero-extended, with bit XLEN-1 equal to `trap_async_i`. The other level's cause register is unchanged.
- R8: The handling level's exception-PC register is loaded with `pc_i`. The other level's register is unchanged.
- R9: The redirect PC is the handling level's trap-vector value with bits 1:0 cleared. Cause*4 is added to it only when the trap is an interrupt and the vector's bits 1:0 equal 01.
- R10: After entry, `priv_o` equals the handling level: 1 for supervisor, 3 for machine.
- R11: `redirect_o` is high for exactly the cycle after each accepted request. With no request, every register output holds its value.
- R12: After reset all registers are zero, `priv_o` is 3 and `redirect_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| trap_valid_i | input | 1 | Trap request, one entry per cycle it is high |
| trap_async_i | input | 1 | 1 = interrupt, 0 = exception |
| trap_cause_i | input | CAUSE_W | Raw cause code |
| trap_value_i | input | XLEN | Faulting address or value |
| pc_i | input | XLEN | PC of the trapping instruction |
| cur_priv_i | input | 2 | Current privilege (0 U, 1 S, 3 M) |
| cur_sie_i | input | 1 | Current supervisor interrupt enable |
| cur_mie_i | input | 1 | Current machine interrupt enable |
| ideleg_i | input | XLEN | Interrupt delegation mask |
| edeleg_i | input | XLEN | Exception delegation mask |
| stvec_i | input | XLEN | Supervisor trap vector (bits 1:0 mode) |
| mtvec_i | input | XLEN | Machine trap vector (bits 1:0 mode) |
| redirect_o | output | 1 | One-cycle redirect strobe |
| redirect_pc_o | output | XLEN | Handler address |
| priv_o | output | 2 | Privilege after entry |
| sie_o | output | 1 | Supervisor interrupt enable after entry |
| spie_o | output | 1 | Supervisor previous interrupt enable |
| spp_o | output | 1 | Supervisor previous privilege |
| mie_o | output | 1 | Machine interrupt enable after entry |
| mpie_o | output | 1 | Machine previous interrupt enable |
| mpp_o | output | 2 | Machine previous privilege |
| scause_o | output | XLEN | Supervisor cause register |
| mcause_o | output | XLEN | Machine cause register |
| sepc_o | output | XLEN | Supervisor exception PC |
| mepc_o | output | XLEN | Machine exception PC |
| stval_o | output | XLEN | Supervisor trap value |
| mtval_o | output | XLEN | Machine trap value |

## Verification
Directed traps cover four routing cases. The first sends the same cause code once as an interrupt and once as an exception, with the two masks set differently, so it shows which mask was read. The second issues environment calls from each level with the masks open and closed, which separates the rewrite from the routing. The third raises traps from machine level and with cause codes of 32 and above while all mask bits are set. The fourth sends faulting causes both synchronously and asynchronously, against vector mode values 0, 1 and 2, which separates value capture and vectored offsets by trap kind. Seeded random traps with random masks, privileges, vectors and idle gaps then test that the registers of the level that did not take the trap stay unchanged.

// File: rtl/trap_pkg.sv
package trap_pkg;

    typedef enum logic [1:0] {
        PRIV_U   = 2'd0,
        PRIV_S   = 2'd1,
        PRIV_RSV = 2'd2,
        PRIV_M   = 2'd3
    } priv_e;

    localparam int unsigned ECALL_U = 8;
    localparam int unsigned ECALL_S = 9;
    localparam int unsigned ECALL_M = 11;

    // Causes whose trap-value register carries the faulting value
    function automatic logic carries_value(input logic [31:0] code);
        case (code)
            32'd0, 32'd1, 32'd4, 32'd5, 32'd6, 32'd7,
            32'd12, 32'd13, 32'd15: carries_value = 1'b1;
            default:                carries_value = 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/trap_cause_fix.sv
module trap_cause_fix
    import trap_pkg::*;
#(
    parameter int CAUSE_W = 6
) (
    input  logic               async_i,
    input  logic [CAUSE_W-1:0] cause_i,
    input  logic [1:0]         priv_i,
    output logic [CAUSE_W-1:0] cause_o,
    output logic               keep_value_o
);

    always_comb begin
        cause_o = cause_i;
        if (!async_i && cause_i == CAUSE_W'(ECALL_U)) begin
            case (priv_e'(priv_i))
                PRIV_S:  cause_o = CAUSE_W'(ECALL_S);
                PRIV_M:  cause_o = CAUSE_W'(ECALL_M);
                default: cause_o = cause_i;
            endcase
        end
        keep_value_o = !async_i && carries_value(32'(cause_i));
    end

endmodule

// File: rtl/trap_route.sv
module trap_route
    import trap_pkg::*;
#(
    parameter int XLEN    = 32,
    parameter int CAUSE_W = 6
) (
    input  logic               async_i,
    input  logic [CAUSE_W-1:0] cause_i,
    input  logic [1:0]         priv_i,
    input  logic [XLEN-1:0]    ideleg_i,
    input  logic [XLEN-1:0]    edeleg_i,
    output logic               to_super_o
);

    localparam int IDX_W = $clog2(XLEN);

    logic [XLEN-1:0] mask;
    logic [31:0]     code;
    logic            in_range;
    logic            low_priv;

    always_comb begin
        mask       = async_i ? ideleg_i : edeleg_i;
        code       = 32'(cause_i);
        in_range   = code < 32'(XLEN);
        low_priv   = (priv_i == PRIV_U) || (priv_i == PRIV_S);
        to_super_o = low_priv && in_range && mask[code[IDX_W-1:0]];
    end

endmodule

// File: rtl/trap_vector.sv
module trap_vector #(
    parameter int XLEN    = 32,
    parameter int CAUSE_W = 6,
    parameter bit VEC_EN  = 1'b1
) (
    input  logic [XLEN-1:0]    tvec_i,
    input  logic               async_i,
    input  logic [CAUSE_W-1:0] cause_i,
    output logic [XLEN-1:0]    pc_o
);

    logic [XLEN-1:0] base;
    assign base = {tvec_i[XLEN-1:2], 2'b00};

    generate
        if (VEC_EN) begin : g_vectored
            logic [XLEN-1:0] offset;
            assign offset = (async_i && tvec_i[1:0] == 2'b01)
                          ? (XLEN'(cause_i) << 2) : '0;
            assign pc_o = base + offset;
        end else begin : g_direct
            assign pc_o = base;
        end
    endgenerate

endmodule

// File: rtl/trap_entry_unit.sv
module trap_entry_unit
    import trap_pkg::*;
#(
    parameter int XLEN    = 32,
    parameter int CAUSE_W = 6,
    parameter bit VEC_EN  = 1'b1
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               trap_valid_i,
    input  logic               trap_async_i,
    input  logic [CAUSE_W-1:0] trap_cause_i,
    input  logic [XLEN-1:0]    trap_value_i,
    input  logic [XLEN-1:0]    pc_i,
    input  logic [1:0]         cur_priv_i,
    input  logic               cur_sie_i,
    input  logic               cur_mie_i,
    input  logic [XLEN-1:0]    ideleg_i,
    input  logic [XLEN-1:0]    edeleg_i,
    input  logic [XLEN-1:0]    stvec_i,
    input  logic [XLEN-1:0]    mtvec_i,
    output logic               redirect_o,
    output logic [XLEN-1:0]    redirect_pc_o,
    output logic [1:0]         priv_o,
    output logic               sie_o,
    output logic               spie_o,
    output logic               spp_o,
    output logic               mie_o,
    output logic               mpie_o,
    output logic [1:0]         mpp_o,
    output logic [XLEN-1:0]    scause_o,
    output logic [XLEN-1:0]    mcause_o,
    output logic [XLEN-1:0]    sepc_o,
    output logic [XLEN-1:0]    mepc_o,
    output logic [XLEN-1:0]    stval_o,
    output logic [XLEN-1:0]    mtval_o
);

    typedef struct packed {
        logic            redirect;
        logic [XLEN-1:0] pc;
        logic [1:0]      priv;
        logic            sie;
        logic            spie;
        logic            spp;
        logic            mie;
        logic            mpie;
        logic [1:0]      mpp;
        logic [XLEN-1:0] scause;
        logic [XLEN-1:0] mcause;
        logic [XLEN-1:0] sepc;
        logic [XLEN-1:0] mepc;
        logic [XLEN-1:0] stval;
        logic [XLEN-1:0] mtval;
    } entry_state_t;

    entry_state_t st_d, st_q;

    logic [CAUSE_W-1:0] cause_fix;
    logic               keep_value;
    logic               to_super;
    logic [XLEN-1:0]    s_target;
    logic [XLEN-1:0]    m_target;

    trap_cause_fix #(.CAUSE_W(CAUSE_W)) i_cause_fix (
        .async_i      (trap_async_i),
        .cause_i      (trap_cause_i),
        .priv_i       (cur_priv_i),
        .cause_o      (cause_fix),
        .keep_value_o (keep_value)
    );

    trap_route #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) i_route (
        .async_i    (trap_async_i),
        .cause_i    (cause_fix),
        .priv_i     (cur_priv_i),
        .ideleg_i   (ideleg_i),
        .edeleg_i   (edeleg_i),
        .to_super_o (to_super)
    );

    trap_vector #(.XLEN(XLEN), .CAUSE_W(CAUSE_W), .VEC_EN(VEC_EN)) i_svec (
        .tvec_i  (stvec_i),
        .async_i (trap_async_i),
        .cause_i (cause_fix),
        .pc_o    (s_target)
    );

    trap_vector #(.XLEN(XLEN), .CAUSE_W(CAUSE_W), .VEC_EN(VEC_EN)) i_mvec (
        .tvec_i  (mtvec_i),
        .async_i (trap_async_i),
        .cause_i (cause_fix),
        .pc_o    (m_target)
    );

    // Next-state computation
    always_comb begin
        logic [XLEN-1:0] cause_word;
        logic [XLEN-1:0] value_word;

        st_d          = st_q;
        st_d.redirect = 1'b0;

        cause_word           = XLEN'(cause_fix);
        cause_word[XLEN-1]   = trap_async_i;
        value_word           = keep_value ? trap_value_i : '0;

        if (trap_valid_i) begin
            st_d.redirect = 1'b1;
            if (to_super) begin
                st_d.spie   = cur_sie_i;
                st_d.spp    = cur_priv_i[0];
                st_d.sie    = 1'b0;
                st_d.scause = cause_word;
                st_d.sepc   = pc_i;
                st_d.stval  = value_word;
                st_d.priv   = PRIV_S;
                st_d.pc     = s_target;
            end else begin
                st_d.mpie   = cur_mie_i;
                st_d.mpp    = cur_priv_i;
                st_d.mie    = 1'b0;
                st_d.mcause = cause_word;
                st_d.mepc   = pc_i;
                st_d.mtval  = value_word;
                st_d.priv   = PRIV_M;
                st_d.pc     = m_target;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q      <= '0;
            st_q.priv <= PRIV_M;
        end else begin
            st_q <= st_d;
        end
    end

    assign redirect_o    = st_q.redirect;
    assign redirect_pc_o = st_q.pc;
    assign priv_o        = st_q.priv;
    assign sie_o         = st_q.sie;
    assign spie_o        = st_q.spie;
    assign spp_o         = st_q.spp;
    assign mie_o         = st_q.mie;
    assign mpie_o        = st_q.mpie;
    assign mpp_o         = st_q.mpp;
    assign scause_o      = st_q.scause;
    assign mcause_o      = st_q.mcause;
    assign sepc_o        = st_q.sepc;
    assign mepc_o        = st_q.mepc;
    assign stval_o       = st_q.stval;
    assign mtval_o       = st_q.mtval;

endmodule

// File: rtl/trap_entry_chk.sv
module trap_entry_chk #(
    parameter int XLEN    = 32,
    parameter int CAUSE_W = 6
) (
    input logic               clk_i,
    input logic               rst_ni,
    input logic               trap_valid_i,
    input logic               trap_async_i,
    input logic [CAUSE_W-1:0] trap_cause_i,
    input logic [XLEN-1:0]    pc_i,
    input logic [1:0]         cur_priv_i,
    input logic               redirect_o,
    input logic [XLEN-1:0]    redirect_pc_o,
    input logic [1:0]         priv_o,
    input logic               mie_o,
    input logic [XLEN-1:0]    mcause_o,
    input logic [XLEN-1:0]    sepc_o,
    input logic [XLEN-1:0]    mepc_o
);

    assert_redirect_follows_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        trap_valid_i |=> redirect_o);

    assert_quiet_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !trap_valid_i |=> (!redirect_o && $stable(mepc_o) && $stable(sepc_o) && $stable(priv_o)));

    assert_machine_stays_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (trap_valid_i && cur_priv_i == 2'd3) |=> (priv_o == 2'd3 && !mie_o && mepc_o == $past(pc_i)));

    assert_async_msb_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (trap_valid_i && trap_async_i && cur_priv_i == 2'd3) |=> mcause_o[XLEN-1]);

    assert_ecall_machine_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (trap_valid_i && !trap_async_i && trap_cause_i == CAUSE_W'(8) && cur_priv_i == 2'd3)
        |=> mcause_o == XLEN'(11));

    assert_target_aligned_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        redirect_o |-> redirect_pc_o[1:0] == 2'b00);

    assert_level_legal_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        redirect_o |-> (priv_o == 2'd1 || priv_o == 2'd3));

endmodule

bind trap_entry_unit trap_entry_chk #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) i_trap_entry_chk (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .trap_valid_i  (trap_valid_i),
    .trap_async_i  (trap_async_i),
    .trap_cause_i  (trap_cause_i),
    .pc_i          (pc_i),
    .cur_priv_i    (cur_priv_i),
    .redirect_o    (redirect_o),
    .redirect_pc_o (redirect_pc_o),
    .priv_o        (priv_o),
    .mie_o         (mie_o),
    .mcause_o      (mcause_o),
    .sepc_o        (sepc_o),
    .mepc_o        (mepc_o)
);

// File: tb/test_trap_entry_unit.sv
module test_trap_entry_unit;

    localparam int XLEN    = 32;
    localparam int CAUSE_W = 6;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               t_valid = 1'b0;
    logic               t_async = 1'b0;
    logic [CAUSE_W-1:0] t_cause = '0;
    logic [XLEN-1:0]    t_value = '0;
    logic [XLEN-1:0]    t_pc = '0;
    logic [1:0]         t_priv = 2'd0;
    logic               t_sie = 1'b0;
    logic               t_mie = 1'b0;
    logic [XLEN-1:0]    ideleg = '0;
    logic [XLEN-1:0]    edeleg = '0;
    logic [XLEN-1:0]    stvec = '0;
    logic [XLEN-1:0]    mtvec = '0;

    logic               redirect;
    logic [XLEN-1:0]    rpc;
    logic [1:0]         priv;
    logic               sie, spie, spp, mie, mpie;
    logic [1:0]         mpp;
    logic [XLEN-1:0]    scause, mcause, sepc, mepc, stval, mtval;

    // expected state
    logic            e_redir, e_sie, e_spie, e_spp, e_mie, e_mpie;
    logic [1:0]      e_priv, e_mpp;
    logic [XLEN-1:0] e_pc, e_scause, e_mcause, e_sepc, e_mepc, e_stval, e_mtval;

    int n_checks = 0;
    int n_fails  = 0;

    always #10 clk = ~clk;

    trap_entry_unit #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) i_trap_entry_unit (
        .clk_i(clk), .rst_ni(rst_n),
        .trap_valid_i(t_valid), .trap_async_i(t_async), .trap_cause_i(t_cause),
        .trap_value_i(t_value), .pc_i(t_pc), .cur_priv_i(t_priv),
        .cur_sie_i(t_sie), .cur_mie_i(t_mie),
        .ideleg_i(ideleg), .edeleg_i(edeleg), .stvec_i(stvec), .mtvec_i(mtvec),
        .redirect_o(redirect), .redirect_pc_o(rpc), .priv_o(priv),
        .sie_o(sie), .spie_o(spie), .spp_o(spp), .mie_o(mie), .mpie_o(mpie), .mpp_o(mpp),
        .scause_o(scause), .mcause_o(mcause), .sepc_o(sepc), .mepc_o(mepc),
        .stval_o(stval), .mtval_o(mtval)
    );

    task automatic chk(input string req, input string what,
                       input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
        end
    endtask

    function automatic logic [CAUSE_W-1:0] fix_cause(input logic a, input logic [CAUSE_W-1:0] c,
                                                     input logic [1:0] p);
        if (!a && c == 6'd8) begin
            if (p == 2'd1) return 6'd9;
            if (p == 2'd3) return 6'd11;
        end
        return c;
    endfunction

    function automatic logic has_value(input logic a, input logic [CAUSE_W-1:0] c);
        if (a) return 1'b0;
        return c inside {6'd0, 6'd1, 6'd4, 6'd5, 6'd6, 6'd7, 6'd12, 6'd13, 6'd15};
    endfunction

    function automatic logic goes_super(input logic a, input logic [CAUSE_W-1:0] c,
                                        input logic [1:0] p);
        logic [XLEN-1:0] m;
        m = a ? ideleg : edeleg;
        if (p > 2'd1) return 1'b0;
        if (c >= 6'd32) return 1'b0;
        return m[c[4:0]];
    endfunction

    function automatic logic [XLEN-1:0] target(input logic [XLEN-1:0] tv, input logic a,
                                               input logic [CAUSE_W-1:0] c);
        logic [XLEN-1:0] t;
        t = tv & ~32'd3;
        if (a && tv[1:0] == 2'b01) t = t + {24'd0, c, 2'b00};
        return t;
    endfunction

    task automatic compare_all();
        chk("R11", "redirect", {31'd0, redirect}, {31'd0, e_redir});
        chk("R9",  "redirect pc", rpc, e_pc);
        chk("R10", "priv", {30'd0, priv}, {30'd0, e_priv});
        chk("R5",  "sie", {31'd0, sie}, {31'd0, e_sie});
        chk("R5",  "spie", {31'd0, spie}, {31'd0, e_spie});
        chk("R5",  "spp", {31'd0, spp}, {31'd0, e_spp});
        chk("R6",  "mie", {31'd0, mie}, {31'd0, e_mie});
        chk("R6",  "mpie", {31'd0, mpie}, {31'd0, e_mpie});
        chk("R6",  "mpp", {30'd0, mpp}, {30'd0, e_mpp});
        chk("R7",  "scause", scause, e_scause);
        chk("R7",  "mcause", mcause, e_mcause);
        chk("R8",  "sepc", sepc, e_sepc);
        chk("R8",  "mepc", mepc, e_mepc);
        chk("R3",  "stval", stval, e_stval);
        chk("R3",  "mtval", mtval, e_mtval);
    endtask

    // Drive at a falling edge, let one rising edge pass, compare at the next falling edge
    task automatic do_trap(input logic a, input logic [CAUSE_W-1:0] c, input logic [1:0] p,
                           input logic [XLEN-1:0] pcv, input logic [XLEN-1:0] val,
                           input logic si, input logic mi);
        logic [CAUSE_W-1:0] fc;
        logic [XLEN-1:0]    cw;
        logic [XLEN-1:0]    vw;
        t_valid = 1'b1; t_async = a; t_cause = c; t_priv = p;
        t_pc = pcv; t_value = val; t_sie = si; t_mie = mi;
        fc = fix_cause(a, c, p);
        cw = {a, 25'd0, fc};
        vw = has_value(a, c) ? val : '0;
        e_redir = 1'b1;
        if (goes_super(a, fc, p)) begin
            e_spie = si; e_spp = p[0]; e_sie = 1'b0;
            e_scause = cw; e_sepc = pcv; e_stval = vw;
            e_priv = 2'd1; e_pc = target(stvec, a, fc);
        end else begin
            e_mpie = mi; e_mpp = p; e_mie = 1'b0;
            e_mcause = cw; e_mepc = pcv; e_mtval = vw;
            e_priv = 2'd3; e_pc = target(mtvec, a, fc);
        end
        @(negedge clk);
        t_valid = 1'b0;
        compare_all();
    endtask

    task automatic idle();
        @(negedge clk);
        e_redir = 1'b0;
        compare_all();
    endtask

    initial begin
        #(20 * 150000);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        e_redir = 0; e_sie = 0; e_spie = 0; e_spp = 0; e_mie = 0; e_mpie = 0;
        e_priv = 2'd3; e_mpp = 0; e_pc = 0; e_scause = 0; e_mcause = 0;
        e_sepc = 0; e_mepc = 0; e_stval = 0; e_mtval = 0;
        repeat (3) @(negedge clk);
        // R12: reset state
        compare_all();
        chk("R12", "reset priv", {30'd0, priv}, 32'd3);
        rst_n = 1'b1;
        idle();

        stvec = 32'h0000_2000;
        mtvec = 32'h0000_1000;

        // R4: ecall rewrite from each level
        edeleg = 32'h0000_0300;  // bits 8 and 9
        do_trap(1'b0, 6'd8, 2'd0, 32'h100, 32'h55, 1'b1, 1'b1);
        chk("R4", "ecall from U", scause, 32'd8);
        do_trap(1'b0, 6'd8, 2'd1, 32'h104, 32'h55, 1'b1, 1'b0);
        chk("R4", "ecall from S", scause, 32'd9);
        edeleg = 32'h0000_0100;  // bit 9 closed
        do_trap(1'b0, 6'd8, 2'd1, 32'h108, 32'h0, 1'b0, 1'b1);
        chk("R4", "ecall from S to M", mcause, 32'd9);
        edeleg = '1;
        do_trap(1'b0, 6'd8, 2'd3, 32'h10c, 32'h0, 1'b1, 1'b1);
        chk("R4", "ecall from M", mcause, 32'd11);
        idle();

        // R1: same code as interrupt and exception, masks differ
        ideleg = 32'h0000_0020; edeleg = 32'h0;
        do_trap(1'b1, 6'd5, 2'd1, 32'h200, 32'h9, 1'b1, 1'b1);
        chk("R1", "interrupt uses ideleg", {30'd0, priv}, 32'd1);
        do_trap(1'b0, 6'd5, 2'd1, 32'h204, 32'h9, 1'b1, 1'b1);
        chk("R1", "exception uses edeleg", {30'd0, priv}, 32'd3);

        // R2: wide cause and machine origin never delegate
        ideleg = '1; edeleg = '1;
        do_trap(1'b0, 6'd40, 2'd0, 32'h300, 32'h0, 1'b0, 1'b0);
        chk("R2", "cause >= XLEN", {30'd0, priv}, 32'd3);
        do_trap(1'b0, 6'd2, 2'd3, 32'h304, 32'h0, 1'b0, 1'b0);
        chk("R2", "from machine", {30'd0, priv}, 32'd3);
        idle();

        // R9: vector modes
        ideleg = '0; edeleg = '0;
        mtvec = 32'h0000_1001;
        do_trap(1'b1, 6'd7, 2'd0, 32'h400, 32'h0, 1'b1, 1'b1);
        chk("R9", "vectored interrupt", rpc, 32'h101c);
        do_trap(1'b0, 6'd7, 2'd0, 32'h404, 32'h77, 1'b1, 1'b1);
        chk("R9", "vectored exception", rpc, 32'h1000);
        mtvec = 32'h0000_1002;
        do_trap(1'b1, 6'd7, 2'd0, 32'h408, 32'h0, 1'b1, 1'b1);
        chk("R9", "mode 2 interrupt", rpc, 32'h1000);

        // R3: value capture
        do_trap(1'b0, 6'd13, 2'd0, 32'h500, 32'hdead_beef, 1'b0, 1'b0);
        chk("R3", "page fault value", mtval, 32'hdead_beef);
        do_trap(1'b0, 6'd2, 2'd0, 32'h504, 32'hdead_beef, 1'b0, 1'b0);
        chk("R3", "illegal no value", mtval, 32'h0);
        do_trap(1'b1, 6'd13, 2'd0, 32'h508, 32'hdead_beef, 1'b0, 1'b0);
        chk("R3", "interrupt no value", mtval, 32'h0);
        idle();
        idle();

        // Random traffic
        for (int i = 0; i < 600; i++) begin
            logic [1:0]         p;
            logic [CAUSE_W-1:0] c;
            int                 r;
            ideleg = $urandom; edeleg = $urandom;
            stvec  = $urandom; mtvec  = $urandom;
            r = $urandom % 3;
            p = (r == 2) ? 2'd3 : 2'(r);
            c = ($urandom % 4 == 0) ? 6'd8 : 6'($urandom % 64);
            do_trap(1'($urandom), c, p, $urandom, $urandom, 1'($urandom), 1'($urandom));
            if ($urandom % 3 == 0) idle();
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule